// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital core of an 8-bit successive-approximation converter that sits on a microprocessor bus. A host starts a conversion by pulling chip select and write low together. It reads the result by pulling chip select and read low together. An active-low interrupt output tells the host that a new result is waiting. The analog side is outside the block: the block drives a trial code toward an external comparator and takes back one decision bit, which is high when the input is at or above the trial code.

All three bus strobes pass through a two-flop synchroniser into the converter clock domain. The block stays in reset for as long as both start strobes are low. When either strobe is released, the block tests the bits from the most significant down, eight converter clocks per bit. It then copies the finished word into an output latch and, one clock later, pulls the interrupt low. If the host issues a new start during a conversion, the running conversion is dropped and the latch keeps its old value. The interrupt output can be wired back to the write input, with chip select held low, so that the block converts continuously.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, intr_n_o is 1, data_oe_o is 0, data_o is 0 and trial_o is 0.
- R2: When the synchronised cs_n_i and wr_n_i are both 0, trial_o is cleared to 0 and intr_n_o is driven to 1.
- R3: While cs_n_i and wr_n_i both stay 0, trial_o stays 0 and intr_n_o stays 1, however long the strobes are held.
- R4: The conversion tests bits from the MSB down. Each bit is set as a trial for 8 clocks, and at the end of that slot it is kept when comp_i is 1 or cleared when comp_i is 0. The first trial code is 0x80. The final word equals the largest code that the comparator accepts, so an input at full scale yields 0xFF and an input at zero yields 0x00.
- R5: intr_n_o falls between 66 and 73 clocks after the start strobes are released. This allows 1 to 8 clocks of start delay, 64 clocks of bit slots and 1 clock for the interrupt.
- R6: The output latch changes only on completion of a conversion. intr_n_o falls on the clock after the latch is loaded.
- R7: While cs_n_i and rd_n_i are both 0 after synchronisation, data_oe_o is 1 and data_o shows the latch, and intr_n_o returns to 1. At all other times data_o reads 0.
- R8: A new start issued during a conversion abandons that conversion and starts a fresh one. The latch keeps the previous result.
- R9: If wr_n_i is tied to intr_n_o with cs_n_i held at 0, a single initial low pulse on wr_n_i gives back-to-back conversions.
- R10: A low wr_n_i while cs_n_i is 1 starts nothing: intr_n_o and the latch are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| wr_n_i | input | 1 | Start strobe, active low, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| comp_i | input | 1 | Comparator decision, 1 when input is at or above trial code |
| trial_o | output | 8 | Trial code driven to the comparator |
| intr_n_o | output | 1 | Conversion-done interrupt, active low |
| data_oe_o | output | 1 | Data bus output enable |
| data_o | output | 8 | Latched result, 0 when not enabled |

## Verification
The assertions check several properties on every clock. A start request clears the trial code and suppresses the interrupt. At most one bit is ever under trial, and the first trial after release is the MSB alone. The latch changes only on a completion pulse. The interrupt falls only two clocks after completion, and a read releases it. The bench's scenarios are needed to show the behaviour that spans a whole conversion: that the result matches the analog input, that the release-to-interrupt latency falls in its window, that a restart leaves the old result in place, that a write without chip select has no effect, and that continuous conversion keeps running when the interrupt is wired back to the write input.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_HOLD = 2'd1,
      SQ_RUN  = 2'd2
   } sq_state_e;

   localparam int STROBE_W = 3;
   localparam int IDX_CS   = 0;
   localparam int IDX_WR   = 1;
   localparam int IDX_RD   = 2;
endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("sar_strobe_sync: WIDTH must be at least 1");
   end
   if (STAGES > 8) begin : g_bad_stages
      $error("sar_strobe_sync: STAGES must not exceed 8");
   end

   if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
         end else begin
            stg[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end

      assign sync_o = stg[STAGES-1];
   end
endmodule

// File: rtl/sar_bit_walker.sv
module sar_bit_walker
   import sar_seq_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLKS_PER_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req_i,
   input  logic              comp_i,
   output logic [DATA_W-1:0] trial_o,
   output logic              done_o
);
   localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam logic [CNT_W-1:0]  SLOT_LAST = CNT_W'(CLKS_PER_BIT - 1);
   localparam logic [DATA_W-1:0] MSB_MASK  = {1'b1, {(DATA_W-1){1'b0}}};

   if (DATA_W < 2) begin : g_bad_dw
      $error("sar_bit_walker: DATA_W must be at least 2");
   end
   if (CLKS_PER_BIT < 1) begin : g_bad_cpb
      $error("sar_bit_walker: CLKS_PER_BIT must be at least 1");
   end

   sq_state_e         state;
   logic [CNT_W-1:0]  slot_cnt;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] sar;
   logic [DATA_W-1:0] decided;

   // keep the bit under trial if the comparator accepts, otherwise drop it
   assign decided = comp_i ? sar : (sar & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         slot_cnt <= '0;
         mask     <= '0;
         sar      <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_req_i) begin
            state    <= SQ_HOLD;
            slot_cnt <= '0;
            mask     <= '0;
            sar      <= '0;
         end else begin
            case (state)
               SQ_HOLD: begin
                  state    <= SQ_RUN;
                  mask     <= MSB_MASK;
                  sar      <= MSB_MASK;
                  slot_cnt <= '0;
               end
               SQ_RUN: begin
                  if (slot_cnt == SLOT_LAST) begin
                     slot_cnt <= '0;
                     if (mask[0]) begin
                        sar    <= decided;
                        mask   <= '0;
                        state  <= SQ_IDLE;
                        done_o <= 1'b1;
                     end else begin
                        sar  <= decided | (mask >> 1);
                        mask <= mask >> 1;
                     end
                  end else begin
                     slot_cnt <= slot_cnt + 1'b1;
                  end
               end
               default: state <= SQ_IDLE;
            endcase
         end
      end
   end

   assign trial_o = sar;

   a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_req_i |=> (trial_o == '0) && !done_o);

   a_r4_single_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask));

   a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HOLD && !start_req_i) |=> (trial_o == MSB_MASK));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLKS_PER_BIT = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic              comp_i,
   output logic [DATA_W-1:0] trial_o,
   output logic              intr_n_o,
   output logic              data_oe_o,
   output logic [DATA_W-1:0] data_o
);
   logic [STROBE_W-1:0] strobe_raw;
   logic [STROBE_W-1:0] strobe_s;
   logic                start_req;
   logic                rd_act;
   logic                done;
   logic                done_d;
   logic [DATA_W-1:0]   latch_q;

   assign strobe_raw[IDX_CS] = cs_n_i;
   assign strobe_raw[IDX_WR] = wr_n_i;
   assign strobe_raw[IDX_RD] = rd_n_i;

   sar_strobe_sync #(
      .WIDTH  (STROBE_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (strobe_raw),
      .sync_o  (strobe_s)
   );

   assign start_req = ~strobe_s[IDX_CS] & ~strobe_s[IDX_WR];
   assign rd_act    = ~strobe_s[IDX_CS] & ~strobe_s[IDX_RD];

   sar_bit_walker #(
      .DATA_W       (DATA_W),
      .CLKS_PER_BIT (CLKS_PER_BIT)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_req_i (start_req),
      .comp_i      (comp_i),
      .trial_o     (trial_o),
      .done_o      (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q  <= '0;
         done_d   <= 1'b0;
         intr_n_o <= 1'b1;
      end else begin
         if (done) latch_q <= trial_o;
         done_d <= done & ~start_req;
         if (start_req)   intr_n_o <= 1'b1;
         else if (done_d) intr_n_o <= 1'b0;
         else if (rd_act) intr_n_o <= 1'b1;
      end
   end

   assign data_oe_o = rd_act;
   assign data_o    = rd_act ? latch_q : '0;

   a_r6_latch_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(latch_q));

   a_r6_intr_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intr_n_o) |-> $past(done, 2));

   a_r7_read_releases_intr: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && !done_d) |=> intr_n_o);

   a_r3_hold_keeps_intr_high: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> intr_n_o);
endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          rd_n = 1'b1;
   logic          free_run = 1'b0;
   logic [DW-1:0] vin = '0;
   logic          comp;
   logic          wr_in;
   logic [DW-1:0] trial;
   logic          intr_n;
   logic          oe;
   logic [DW-1:0] dout;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign comp  = (vin >= trial);
   assign wr_in = wr_n & (free_run ? intr_n : 1'b1);

   sar_seq_ctrl u_sar_seq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_i    (cs_n),
      .wr_n_i    (wr_in),
      .rd_n_i    (rd_n),
      .comp_i    (comp),
      .trial_o   (trial),
      .intr_n_o  (intr_n),
      .data_oe_o (oe),
      .data_o    (dout)
   );

   // independent model of the bit walk against an ideal comparator
   function automatic logic [DW-1:0] exp_code(input logic [DW-1:0] v);
      logic [DW-1:0] c;
      c = '0;
      for (int b = DW - 1; b >= 0; b--) begin
         c[b] = 1'b1;
         if (!(v >= c)) c[b] = 1'b0;
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_pulse(input int width);
      @(negedge clk);
      cs_n = 1'b0;
      wr_n = 1'b0;
      repeat (width) @(negedge clk);
      wr_n = 1'b1;
      cs_n = 1'b1;
   endtask

   task automatic wait_intr(output int cyc);
      cyc = 0;
      while (intr_n && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic read_word(output logic [DW-1:0] v, output logic en);
      @(negedge clk);
      cs_n = 1'b0;
      rd_n = 1'b0;
      repeat (4) @(negedge clk);
      v  = dout;
      en = oe;
      cs_n = 1'b1;
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic convert_and_check(input logic [DW-1:0] v, input string tag);
      int cyc;
      logic [DW-1:0] got;
      logic en;
      vin = v;
      start_pulse(2);
      wait_intr(cyc);
      chk(cyc >= 66 && cyc <= 73, {tag, " R5 latency"}, cyc, 69);
      read_word(got, en);
      chk(en === 1'b1, "R7 output enable during read", en, 1);
      chk(got === exp_code(v), {tag, " R4 result"}, got, exp_code(v));
      chk(intr_n === 1'b1, "R7 intr released by read", intr_n, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int cyc;
      int falls;
      logic [DW-1:0] got;
      logic en;
      logic prev;
      bit ok;
      void'($urandom(32'h5EED));

      repeat (3) @(negedge clk);
      chk(intr_n === 1'b1, "R1 reset intr", intr_n, 1);
      chk(oe === 1'b0, "R1 reset oe", oe, 0);
      chk(dout === '0, "R1 reset data", dout, 0);
      chk(trial === '0, "R1 reset trial", trial, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 walk order: first trial 0x80, then bit7 decided and bit6 on trial
      vin = 8'hA5;
      start_pulse(2);
      repeat (5) @(negedge clk);
      chk(trial === 8'h80, "R4 first trial MSB", trial, 8'h80);
      repeat (8) @(negedge clk);
      chk(trial === 8'hC0, "R4 second trial", trial, 8'hC0);
      wait_intr(cyc);
      read_word(got, en);
      chk(got === 8'hA5, "R4 walked result", got, 8'hA5);

      // corner codes
      convert_and_check(8'hFF, "full scale");
      convert_and_check(8'h00, "zero");
      convert_and_check(8'h80, "mid");
      convert_and_check(8'h7F, "below mid");

      // R3: wide start strobe holds the block in reset
      vin = 8'h3C;
      @(negedge clk);
      cs_n = 1'b0;
      wr_n = 1'b0;
      repeat (4) @(negedge clk);
      ok = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (trial !== '0 || intr_n !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R3 held in reset", trial, 0);
      chk(intr_n === 1'b1, "R2 intr high on start", intr_n, 1);
      wr_n = 1'b1;
      cs_n = 1'b1;
      wait_intr(cyc);
      chk(cyc >= 66 && cyc <= 73, "R5 latency after wide strobe", cyc, 69);
      read_word(got, en);
      chk(got === 8'h3C, "R3 result after hold", got, 8'h3C);

      // R7: no read -> data reads zero
      repeat (3) @(negedge clk);
      chk(dout === '0 && oe === 1'b0, "R7 idle bus reads zero", dout, 0);

      // R8: restart mid-conversion keeps old latch
      vin = 8'h11;
      start_pulse(2);
      repeat (30) @(negedge clk);
      vin = 8'hE7;
      start_pulse(2);
      repeat (20) @(negedge clk);
      read_word(got, en);
      chk(got === 8'h3C, "R8 latch kept across restart", got, 8'h3C);
      wait_intr(cyc);
      chk(cyc >= 30 && cyc <= 60, "R8 restarted conversion completes", cyc, 45);
      read_word(got, en);
      chk(got === 8'hE7, "R8 new result", got, 8'hE7);

      // R10: write without chip select does nothing
      vin = 8'h55;
      start_pulse(2);
      wait_intr(cyc);
      @(negedge clk);
      wr_n = 1'b0;
      repeat (6) @(negedge clk);
      wr_n = 1'b1;
      repeat (80) @(negedge clk);
      chk(intr_n === 1'b0, "R10 intr unchanged", intr_n, 0);
      read_word(got, en);
      chk(got === 8'h55, "R10 latch unchanged", got, 8'h55);
      // R2: a start clears the trial code
      vin = 8'h99;
      @(negedge clk);
      cs_n = 1'b0;
      wr_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(trial === '0, "R2 trial cleared on start", trial, 0);
      wr_n = 1'b1;
      cs_n = 1'b1;
      wait_intr(cyc);
      read_word(got, en);

      // random conversions
      for (int k = 0; k < 20; k++) begin
         convert_and_check(DW'($urandom_range(255, 0)), "random");
      end

      // R9: free-running via intr fed back to wr
      vin = 8'hC3;
      @(negedge clk);
      free_run = 1'b1;
      cs_n = 1'b0;
      wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      falls = 0;
      prev  = intr_n;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (prev && !intr_n) falls++;
         prev = intr_n;
      end
      chk(falls >= 4, "R9 continuous conversions", falls, 5);
      wait_intr(cyc);
      free_run = 1'b0;
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
      read_word(got, en);
      chk(got === 8'hC3, "R9 free-run result", got, 8'hC3);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule